// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block sits in the read path of a nonvolatile memory. It lets software follow an internal program or erase operation by reading. While the operation runs, reads do not return the stored data. Two bits of the read bus carry progress information instead. Bit 7 is a polarity flag: during a program it is the complement of bit 7 of the byte being written, and during an erase it is zero. Bit 6 flips on every new read access. Once the operation ends, reads return the stored contents unchanged. An active-low ready/busy line gives the same information without any read.

The block takes four things from the rest of the device: a busy flag from the operation sequencer, the operation type, the last byte loaded for programming, and the data read from the array. It also takes the host's read strobe. A new operation is recognised on the first clock edge where busy is seen high after being low. The operation type and the polarity bit are captured on that edge, so changes to those inputs during the operation are not seen. The address used during polling plays no part.

Top module: `op_status_reporter`

## Requirements
- R1: Under reset, and on the first cycles after it with busy low, `rdyBsyN` is 1 and `rdData` equals `arrayData`.
- R2: `rdyBsyN` is 0 in the cycle after a clock edge that samples `opBusy` high. It is 1 in the cycle after an edge that samples `opBusy` low.
- R3: During a program operation (`opIsErase` = 0 at the start edge), `rdData[7]` is the complement of `loadData[7]` as sampled on the start edge. Later changes to `loadData` have no effect.
- R4: During an erase operation (`opIsErase` = 1 at the start edge), `rdData[7]` is 0.
- R5: While busy, `rdData[6]` inverts once for each rising edge of `rdStrobe`. A rising edge is an edge that samples `rdStrobe` high after sampling it low. Holding the strobe high causes no further change.
- R6: `rdData[6]` reads 0 at the start of every operation, before any strobe rising edge.
- R7: While busy, every bit of `rdData` other than bits 7 and 6 equals the same bit of `arrayData`.
- R8: While not busy, `rdData` equals `arrayData`, and read strobes have no effect on it.
- R9: Changing `opIsErase` while an operation runs does not change the reported bit 7 until a new operation starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opBusy | input | 1 | Internal program or erase in progress |
| opIsErase | input | 1 | 1 = erase, 0 = program; sampled at operation start |
| loadData | input | DW | Last data loaded for programming |
| rdStrobe | input | 1 | Host read access strobe |
| arrayData | input | DW | Data read from the storage array |
| rdData | output | DW | Read data returned to the host |
| rdyBsyN | output | 1 | 0 while an operation is in progress |

## Verification
`opBusy` passes through one register, so `rdyBsyN` and the switch of `rdData` into status mode take effect one clock after the edge that samples the new busy level. A strobe rising edge changes bit 6 after the same edge. Bits that pass `arrayData` through follow it within the same cycle. The bench drives inputs on the falling clock edge and compares every output on the next falling edge. Its reference model advances on the rising edges in between, so each expected value already includes the one-register delay.

// File: rtl/op_status_pkg.sv
package op_status_pkg;
  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;

  typedef struct packed {
    logic startOp;     // first busy cycle: capture polarity, clear toggle
    logic showStatus;  // substitute status bits on the read bus
    logic flipToggle;  // a new read access seen while busy
  } stsCtrl_t;
endpackage

// File: rtl/op_status_ctrl.sv
module op_status_ctrl
  import op_status_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     opBusy,
  input  logic     rdStrobe,
  output stsCtrl_t ctrl,
  output logic     rdyBsyN
);
  logic busyQ;
  logic strobeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyQ <= 1'b0;
    else       busyQ <= opBusy;
  end

  // previous strobe level, used only for edge detection
  always_ff @(posedge clk) strobeQ <= rdStrobe;

  always_comb begin
    ctrl.startOp    = opBusy && !busyQ;
    ctrl.showStatus = busyQ;
    ctrl.flipToggle = busyQ && opBusy && rdStrobe && !strobeQ;
  end

  assign rdyBsyN = ~busyQ;

  // R6
  start_not_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.startOp |-> !ctrl.flipToggle);
endmodule

// File: rtl/op_status_dp.sv
module op_status_dp
  import op_status_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  stsCtrl_t      ctrl,
  input  logic          opIsErase,
  input  logic [DW-1:0] loadData,
  input  logic [DW-1:0] arrayData,
  output logic [DW-1:0] rdData
);
  logic pollQ;
  logic togQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pollQ <= 1'b0;
      togQ  <= 1'b0;
    end else if (ctrl.startOp) begin
      pollQ <= opIsErase ? 1'b0 : ~loadData[POLL_BIT];
      togQ  <= 1'b0;
    end else if (ctrl.flipToggle) begin
      togQ  <= ~togQ;
    end
  end

  for (genvar b = 0; b < DW; b++) begin : g_bit
    if (b == POLL_BIT) begin : g_poll
      assign rdData[b] = ctrl.showStatus ? pollQ : arrayData[b];
    end else if (b == TOG_BIT) begin : g_tog
      assign rdData[b] = ctrl.showStatus ? togQ : arrayData[b];
    end else begin : g_pass
      assign rdData[b] = arrayData[b];
    end
  end

  // R6
  start_clears_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.startOp |=> (togQ == 1'b0));
endmodule

// File: rtl/op_status_reporter.sv
module op_status_reporter
  import op_status_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          opBusy,
  input  logic          opIsErase,
  input  logic [DW-1:0] loadData,
  input  logic          rdStrobe,
  input  logic [DW-1:0] arrayData,
  output logic [DW-1:0] rdData,
  output logic          rdyBsyN
);
  stsCtrl_t ctrl;

  initial begin
    if (DW <= POLL_BIT) $error("DW must cover the polling bit");
  end

  op_status_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opBusy(opBusy), .rdStrobe(rdStrobe),
    .ctrl(ctrl), .rdyBsyN(rdyBsyN)
  );

  op_status_dp #(.DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .opIsErase(opIsErase),
    .loadData(loadData), .arrayData(arrayData), .rdData(rdData)
  );

  // R2
  busy_drives_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    opBusy |=> !rdyBsyN);
  // R2
  idle_releases_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opBusy |=> rdyBsyN);
  // R8
  idle_passthrough_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdyBsyN |-> (rdData == arrayData));
  // R4
  erase_poll_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opBusy && rdyBsyN && opIsErase) |=> (rdData[POLL_BIT] == 1'b0));
  // R3
  prog_poll_inv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opBusy && rdyBsyN && !opIsErase) |=> (rdData[POLL_BIT] == ~$past(loadData[POLL_BIT])));
  // R5
  toggle_flips_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdyBsyN && opBusy && rdStrobe && !$past(rdStrobe))
      |=> (rdData[TOG_BIT] != $past(rdData[TOG_BIT])));
  // R5
  toggle_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdyBsyN && opBusy && !(rdStrobe && !$past(rdStrobe)))
      |=> $stable(rdData[TOG_BIT]));
endmodule

// File: tb/op_status_reporter_test.sv
module op_status_reporter_test;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN;
  logic          opBusy;
  logic          opIsErase;
  logic [DW-1:0] loadData;
  logic          rdStrobe;
  logic [DW-1:0] arrayData;
  logic [DW-1:0] rdData;
  logic          rdyBsyN;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 0;

  // reference state built from the requirements
  logic mBusy, mPol, mTog, mPrev;

  always #2 clk = ~clk;

  op_status_reporter #(.DW(DW)) uut (
    .clk(clk), .rstN(rstN), .opBusy(opBusy), .opIsErase(opIsErase),
    .loadData(loadData), .rdStrobe(rdStrobe), .arrayData(arrayData),
    .rdData(rdData), .rdyBsyN(rdyBsyN)
  );

  always @(posedge clk) begin
    mPrev <= rdStrobe;
    if (!rstN) begin
      mBusy <= 1'b0; mPol <= 1'b0; mTog <= 1'b0;
    end else begin
      if (opBusy && !mBusy) begin
        mPol <= opIsErase ? 1'b0 : ~loadData[7];
        mTog <= 1'b0;
      end else if (mBusy && opBusy && rdStrobe && !mPrev) begin
        mTog <= ~mTog;
      end
      mBusy <= opBusy;
    end
  end

  function automatic logic [DW-1:0] expData(logic busy, logic pol, logic tog,
                                             logic [DW-1:0] arr);
    logic [DW-1:0] e;
    e = arr;
    if (busy) begin
      e[7] = pol;
      e[6] = tog;
    end
    return e;
  endfunction

  task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    testCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic [DW-1:0] e;
    e = expData(mBusy, mPol, mTog, arrayData);
    check("R2", {{(DW-1){1'b0}}, rdyBsyN}, {{(DW-1){1'b0}}, ~mBusy});
    if (!mBusy) begin
      check("R8", rdData, e);
    end else begin
      check(mPol === 1'b0 && opIsErase ? "R4" : "R3", {{(DW-1){1'b0}}, rdData[7]},
            {{(DW-1){1'b0}}, e[7]});
      check("R5", {{(DW-1){1'b0}}, rdData[6]}, {{(DW-1){1'b0}}, e[6]});
      check("R7", rdData & 8'h3F, e & 8'h3F);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    int unsigned seedV;
    int busyLeft;
    seedV = $urandom(32'd4242);
    rstN = 1'b0; opBusy = 1'b0; opIsErase = 1'b0; loadData = '0;
    rdStrobe = 1'b0; arrayData = 8'h5A;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {{(DW-1){1'b0}}, rdyBsyN}, {{(DW-1){1'b0}}, 1'b1});
    check("R1", rdData, 8'h5A);
    rstN = 1'b1;
    tick();
    check("R1", rdData, arrayData);

    // R8: idle strobes do not change the read data
    arrayData = 8'hC3; rdStrobe = 1'b1; tick();
    check("R8", rdData, 8'hC3);
    rdStrobe = 1'b0; tick();

    // program with loadData[7]=1 -> poll bit 0; R6 toggle starts at 0
    loadData = 8'h80; opIsErase = 1'b0; opBusy = 1'b1; arrayData = 8'hFF;
    tick();
    check("R3", {7'd0, rdData[7]}, 8'd0);
    check("R6", {7'd0, rdData[6]}, 8'd0);
    loadData = 8'h00; opIsErase = 1'b1; // R3/R9: ignored mid-operation
    tick();
    check("R9", {7'd0, rdData[7]}, 8'd0);
    rdStrobe = 1'b1; tick();
    check("R5", {7'd0, rdData[6]}, 8'd1);
    tick(); tick(); // held strobe: no further flip
    check("R5", {7'd0, rdData[6]}, 8'd1);
    rdStrobe = 1'b0; tick();
    rdStrobe = 1'b1; tick();
    check("R5", {7'd0, rdData[6]}, 8'd0);
    check("R7", rdData & 8'h3F, 8'h3F);
    rdStrobe = 1'b0; opBusy = 1'b0; tick();
    check("R8", rdData, arrayData);

    // erase: poll bit 0 regardless of loadData
    loadData = 8'h00; opIsErase = 1'b1; opBusy = 1'b1; arrayData = 8'hA5;
    tick();
    check("R4", {7'd0, rdData[7]}, 8'd0);
    check("R6", {7'd0, rdData[6]}, 8'd0);
    opIsErase = 1'b0; tick();
    check("R9", {7'd0, rdData[7]}, 8'd0);
    opBusy = 1'b0; tick();

    // program with loadData[7]=0 -> poll bit 1
    loadData = 8'h12; opIsErase = 1'b0; opBusy = 1'b1; tick();
    check("R3", {7'd0, rdData[7]}, 8'd1);
    opBusy = 1'b0; tick();

    // constrained random traffic
    busyLeft = 0;
    for (int i = 0; i < 4000; i++) begin
      if (busyLeft > 0) busyLeft--;
      else if (($urandom % 100) < 6) busyLeft = 4 + ($urandom % 40);
      opBusy    = (busyLeft > 0);
      opIsErase = $urandom[0];
      loadData  = DW'($urandom);
      arrayData = DW'($urandom);
      rdStrobe  = (($urandom % 100) < 45);
      tick();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule